// File: doc/BRIEF.md
# Multi-Word Instruction Fetch Sequencer

This block is the control sequencer of a small 16-bit processor whose instructions span one, two or three words. It owns the program counter and a three-slot instruction register. It steps through a fetch of the leading word, then a decode that pulls in as many extension words as the leading word asks for, then a single execute cycle. Memory is read through a word-aligned port that answers combinationally in the same cycle, so every word fetch costs exactly one clock. The counter moves forward by one word (two byte addresses) for each word read. When decode ends, the counter therefore points past the whole instruction.

The execute cycle raises a strobe for the downstream datapath. It also resolves the one control-flow operation this block handles itself: a relative jump conditioned on the carry input. The target is the post-decode counter plus twice a signed 10-bit offset. The offset comes from the leading word, so jumps can go forwards or backwards, and the address arithmetic wraps modulo 2^16.

The controller has four states. FETCH reads the leading word into slot 0. EXT1 reads the first extension word into slot 1. EXT2 reads the second extension word into slot 2. EXEC raises the execute strobe and may load the jump target. The transitions are:
- FETCH to EXEC when the fetched word needs no extension.
- FETCH to EXT1 otherwise.
- EXT1 to EXT2 when two extensions are needed.
- EXT1 to EXEC when only one is needed.
- EXT2 to EXEC always.
- EXEC to FETCH always.
- Reset forces FETCH from any state.

Top module: `fseq_top`

## Requirements
- R1: While reset is asserted (active low, asynchronous), the PC equals the reset vector with bit 0 cleared, all three IR slots are zero, the execute strobe is low, and the state is FETCH.
- R2: In FETCH the read strobe is high and the address equals the PC. The word read is placed in IR slot 0, and the PC is larger by 2 in the next cycle. PC bit 0 is always 0.
- R3: The number of extension words is the field in bits [13:12] of the leading word: 0 gives none, 1 gives one, and 2 or 3 give two. Execute follows immediately after the last word fetched.
- R4: Extension words are read at the current PC, into slot 1 and then slot 2, and the PC is advanced by 2 after each. A slot not being written keeps its value.
- R5: In the EXEC cycle the PC equals the leading word's address plus 2 × (1 + number of extension words), modulo 2^16.
- R6: EXEC lasts exactly one cycle with the execute strobe high and the read strobe low, and FETCH follows.
- R7: A leading word with bits [15:14] = 2'b11 is a carry jump. If carry is high in its EXEC cycle, the next PC is the post-decode PC + 2 × sign-extended bits [9:0], modulo 2^16.
- R8: If carry is low, or the leading word is not a carry jump, EXEC leaves the PC unchanged, so the next fetch reads the word after the instruction.
- R9: Carry is sampled only in EXEC. Its value in FETCH, EXT1 and EXT2 has no effect on the PC or on the IR slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_vec | input | 16 | Start address loaded into the PC during reset (bit 0 ignored) |
| mem_addr | output | 16 | Byte address of the word being read (equals PC) |
| mem_rd | output | 1 | Read strobe, high in FETCH, EXT1 and EXT2 |
| mem_rdata | input | 16 | Word returned by memory in the same cycle |
| carry | input | 1 | Carry flag used by the conditional jump |
| pc | output | 16 | Program counter |
| ir0 | output | 16 | Instruction register slot 0 (leading word) |
| ir1 | output | 16 | Instruction register slot 1 (first extension) |
| ir2 | output | 16 | Instruction register slot 2 (second extension) |
| exec_stb | output | 1 | High for the single execute cycle |

## Verification
Two things meet in the EXEC cycle. The PC has just been advanced past every extension word, and the jump adder works from that same, already-advanced PC. A taken jump is therefore wrong if either the decode length or the offset arithmetic is wrong. The bench provokes this with jumps that carry their own extension word, with backward offsets that land in the middle of an earlier instruction, and with a three-word instruction that runs through the top of the address space. A carry pattern from an LFSR varies every cycle, so carry values outside EXEC must be seen to have no effect. Each cycle the PC, the slots and the strobes are judged against a behavioural model, and fixed checks pin down the +7 jump from F812h to F820h and the wrap to 0002h.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXT1  = 2'd1,
        ST_EXT2  = 2'd2,
        ST_EXEC  = 2'd3
    } fseq_state_e;

endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
#(
    parameter int LEN_W = 2,
    parameter int SLOTS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] len_fetch,
    input  logic [LEN_W-1:0] len_held,
    output logic             mem_rd,
    output logic             exec_stb,
    output logic [SLOTS-1:0] load_slot
);

    localparam logic [LEN_W-1:0] MAX_EXT = LEN_W'(SLOTS - 1);
    localparam logic [LEN_W-1:0] TWO_EXT = LEN_W'(2);

    fseq_state_e state_q, state_d;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
        return (l > MAX_EXT) ? MAX_EXT : l;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: state_d = (clamp_len(len_fetch) == '0) ? ST_EXEC : ST_EXT1;
            ST_EXT1:  state_d = (clamp_len(len_held) >= TWO_EXT) ? ST_EXT2 : ST_EXEC;
            ST_EXT2:  state_d = ST_EXEC;
            ST_EXEC:  state_d = ST_FETCH;
        endcase
    end

    always_comb begin
        mem_rd    = 1'b1;
        exec_stb  = 1'b0;
        load_slot = '0;
        unique case (state_q)
            ST_FETCH: load_slot[0] = 1'b1;
            ST_EXT1:  load_slot[1] = 1'b1;
            ST_EXT2:  load_slot[2] = 1'b1;
            ST_EXEC: begin
                mem_rd   = 1'b0;
                exec_stb = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fseq_pc.sv
module fseq_pc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:1] reset_hi,
    input  logic         advance,
    input  logic         load,
    input  logic [W-1:1] target_hi,
    output logic [W-1:0] pc
);

    logic [W-1:1] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_q <= reset_hi;
        else if (load)    word_q <= target_hi;
        else if (advance) word_q <= word_q + 1'b1;
    end

    assign pc = {word_q, 1'b0};

endmodule

// File: rtl/fseq_irbank.sv
module fseq_irbank #(
    parameter int W     = 16,
    parameter int SLOTS = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SLOTS-1:0]        load_slot,
    input  logic [W-1:0]            wdata,
    output logic [SLOTS-1:0][W-1:0] slot_q
);

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            slot_q[i] <= '0;
            else if (load_slot[i]) slot_q[i] <= wdata;
        end
    end

endmodule

// File: rtl/fseq_jump.sv
module fseq_jump #(
    parameter int W     = 16,
    parameter int OFF_W = 10,
    parameter int OPC_W = 2,
    parameter logic [OPC_W-1:0] JMP_OPC = '1
) (
    input  logic             exec,
    input  logic             carry,
    input  logic [OPC_W-1:0] opc,
    input  logic [OFF_W-1:0] offset,
    input  logic [W-1:1]     pc_hi,
    output logic             taken,
    output logic [W-1:1]     target_hi
);

    localparam int EXT_W = W - 1 - OFF_W;

    logic [W-1:1] off_words;

    assign off_words = {{EXT_W{offset[OFF_W-1]}}, offset};
    assign taken     = exec && carry && (opc == JMP_OPC);
    assign target_hi = pc_hi + off_words;

endmodule

// File: rtl/fseq_top.sv
module fseq_top #(
    parameter int DATA_W  = 16,
    parameter int LEN_LSB = 12,
    parameter int LEN_W   = 2,
    parameter int OFF_W   = 10,
    parameter int OPC_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] reset_vec,
    output logic [DATA_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              carry,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] ir0,
    output logic [DATA_W-1:0] ir1,
    output logic [DATA_W-1:0] ir2,
    output logic              exec_stb
);

    localparam int SLOTS = 3;

    logic [SLOTS-1:0]             load_slot;
    logic [SLOTS-1:0][DATA_W-1:0] slot_q;
    logic                         jmp_taken;
    logic [DATA_W-1:1]            jmp_target;

    fseq_ctrl #(.LEN_W(LEN_W), .SLOTS(SLOTS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_fetch (mem_rdata[LEN_LSB +: LEN_W]),
        .len_held  (slot_q[0][LEN_LSB +: LEN_W]),
        .mem_rd    (mem_rd),
        .exec_stb  (exec_stb),
        .load_slot (load_slot)
    );

    fseq_pc #(.W(DATA_W)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .reset_hi  (reset_vec[DATA_W-1:1]),
        .advance   (mem_rd),
        .load      (jmp_taken),
        .target_hi (jmp_target),
        .pc        (pc)
    );

    fseq_irbank #(.W(DATA_W), .SLOTS(SLOTS)) u_ir (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_slot (load_slot),
        .wdata     (mem_rdata),
        .slot_q    (slot_q)
    );

    fseq_jump #(.W(DATA_W), .OFF_W(OFF_W), .OPC_W(OPC_W)) u_jump (
        .exec      (exec_stb),
        .carry     (carry),
        .opc       (slot_q[0][DATA_W-1 -: OPC_W]),
        .offset    (slot_q[0][OFF_W-1:0]),
        .pc_hi     (pc[DATA_W-1:1]),
        .taken     (jmp_taken),
        .target_hi (jmp_target)
    );

    assign mem_addr = pc;
    assign ir0      = slot_q[0];
    assign ir1      = slot_q[1];
    assign ir2      = slot_q[2];

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
    parameter int W     = 16,
    parameter int OFF_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_rd,
    input logic             exec_stb,
    input logic             carry,
    input logic [W-1:0]     pc,
    input logic [1:0]       jopc,
    input logic [OFF_W-1:0] joff
);

    // R2
    pc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc[0] == 1'b0);

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> pc == $past(pc) + W'(2));

    // R6
    exec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |-> !mem_rd);

    // R6
    exec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |=> !exec_stb);

    // R8
    no_jump_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && !carry) |=> pc == $past(pc));

    // R7
    jump_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && carry && jopc == 2'b11) |=>
            pc == $past(pc) + {{(W-1-OFF_W){$past(joff[OFF_W-1])}}, $past(joff), 1'b0});

endmodule

bind fseq_top fseq_chk #(.W(DATA_W), .OFF_W(OFF_W)) u_fseq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rd   (mem_rd),
    .exec_stb (exec_stb),
    .carry    (carry),
    .pc       (pc),
    .jopc     (ir0[DATA_W-1 -: 2]),
    .joff     (ir0[OFF_W-1:0])
);

// File: tb/fseq_top_bench.sv
module fseq_top_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] reset_vec;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [15:0] mem_rdata;
    logic        carry;
    logic [15:0] pc, ir0, ir1, ir2;
    logic        exec_stb;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    fseq_top u_fseq_top (
        .clk(clk), .rst_n(rst_n), .reset_vec(reset_vec),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .carry(carry), .pc(pc), .ir0(ir0), .ir1(ir1), .ir2(ir2),
        .exec_stb(exec_stb)
    );

    function automatic logic [15:0] prog(input logic [15:0] a);
        case (a)
            16'hF800: return 16'h1123;
            16'hF802: return 16'hAAAA;
            16'hF804: return 16'h2456;
            16'hF806: return 16'h1111;
            16'hF808: return 16'h2222;
            16'hF80A: return 16'h3000;
            16'hF80C: return 16'h3333;
            16'hF80E: return 16'h4444;
            16'hF810: return 16'hC007;
            16'hF820: return 16'hD3FE;
            16'hF822: return 16'hBEEF;
            16'hF824: return 16'hC3F8;
            16'hF826: return 16'hC3F0;
            16'hFFFC: return 16'h3000;
            16'hFFFE: return 16'h1234;
            16'h0000: return 16'h5678;
            16'h0002: return 16'hC3FC;
            default:  return 16'h0000;
        endcase
    endfunction

    assign mem_rdata = prog(mem_addr);

    // behavioural reference
    int          ms;
    int          mext;
    logic [15:0] mpc, m0, m1, m2;
    bit          last_taken;
    logic [15:0] lf = 16'hACE1;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset(input logic [15:0] rv);
        ms = 0; mext = 0; mpc = rv & 16'hFFFE;
        m0 = '0; m1 = '0; m2 = '0; last_taken = 1'b0;
    endtask

    task automatic compare();
        chk(mem_rd == (ms != 3), "R6 read strobe", 16'(mem_rd), 16'(ms != 3));
        chk(exec_stb == (ms == 3), "R3 execute position", 16'(exec_stb), 16'(ms == 3));
        if (ms == 3)
            chk(pc == mpc, "R5 post-decode pc", pc, mpc);
        else if (ms == 0)
            chk(pc == mpc, last_taken ? "R7 jump target" : "R8 fall-through pc", pc, mpc);
        else
            chk(pc == mpc, "R9 pc during decode", pc, mpc);
        if (ms != 3) chk(mem_addr == mpc, "R2 read address", mem_addr, mpc);
        chk(ir0 == m0, "R2 slot 0", ir0, m0);
        chk(ir1 == m1, "R4 slot 1", ir1, m1);
        chk(ir2 == m2, "R4 slot 2", ir2, m2);
    endtask

    task automatic model_step();
        logic [15:0] w;
        logic [15:0] soff;
        w = prog(mpc);
        case (ms)
            0: begin
                m0 = w; mpc = mpc + 16'd2;
                mext = (w[13:12] == 2'd3) ? 2 : int'(w[13:12]);
                ms = (mext == 0) ? 3 : 1;
            end
            1: begin
                m1 = w; mpc = mpc + 16'd2;
                ms = (mext == 2) ? 2 : 3;
            end
            2: begin
                m2 = w; mpc = mpc + 16'd2; ms = 3;
            end
            default: begin
                last_taken = (m0[15:14] == 2'b11) && carry;
                if (last_taken) begin
                    soff = {{6{m0[9]}}, m0[9:0]};
                    mpc  = mpc + (soff << 1);
                end
                ms = 0;
            end
        endcase
    endtask

    task automatic run(input int n, input bit force_c);
        for (int i = 0; i < n; i++) begin
            compare();
            carry = force_c ? 1'b1 : lf[0];
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            model_step();
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; reset_vec = 16'hF801; carry = 1'b0;
        repeat (3) @(negedge clk);
        chk(pc == 16'hF800, "R1 reset pc", pc, 16'hF800);
        chk(ir0 == 0 && ir1 == 0 && ir2 == 0, "R1 reset slots", ir0 | ir1 | ir2, 16'h0);
        chk(!exec_stb && mem_rd, "R1 reset strobes", {14'h0, exec_stb, mem_rd}, 16'h0001);
        model_reset(16'hF801);
        rst_n = 1'b1;
        run(13, 1'b1);
        chk(pc == 16'hF820, "R7 jump +7 from F812", pc, 16'hF820);
        run(2000, 1'b0);

        rst_n = 1'b0; reset_vec = 16'hFFFD;
        @(negedge clk);
        chk(pc == 16'hFFFC, "R1 reset mid-run pc", pc, 16'hFFFC);
        chk(ir0 == 0 && ir1 == 0 && ir2 == 0, "R1 reset mid-run slots", ir0 | ir1 | ir2, 16'h0);
        chk(!exec_stb, "R1 reset mid-run strobe", 16'(exec_stb), 16'h0);
        model_reset(16'hFFFD);
        rst_n = 1'b1;
        run(3, 1'b1);
        chk(pc == 16'h0002 && exec_stb, "R5 wrap past FFFE", pc, 16'h0002);
        chk(ir2 == 16'h5678, "R3 length 3 read as 2", ir2, 16'h5678);
        run(600, 1'b0);

        summary();
        $finish;
    end

endmodule